// File: doc/BRIEF.md
# Configurable SPI Character Shift Engine

This block is the serial core of an SPI master. It moves one character of 4 to 16 bits at a time. It drives the serial clock, the outgoing data line and a chip select, and it samples the incoming data line. A 32-bit mode word sets the character length, the clock polarity and phase, the bit order, the chip-select level and a two-stage clock prescaler. The mode word is loaded with a one-cycle strobe while the engine is idle.

A character begins with a one-cycle `start` while `busy` is low. The engine takes `tx_data` right-justified, shifts the character out and collects the reply. It then pulses `done` for one cycle, and the received character is valid on `rx_data` in that cycle. A separate hold input keeps the chip select asserted between characters, so a multi-character frame can run under one continuous select.

Top module: `spi_char_engine`

## Requirements
- R1: After reset the engine is idle: `busy`=0, `done`=0, `sclk`=0 and `csel`=1. The mode in force is word 0x0010_0008, which gives 4-bit characters, a half period of 2 cycles, idle-low clock, sampling on the first edge, least significant bit first and an active-low select.
- R2: `tx_data` and `rx_data` are right-justified. When mode bit 29 is 1 the character's most significant bit is sent and received first; when it is 0 the least significant bit goes first. Transmit bits above the length are never sent, and receive bits above the length read 0.
- R3: Mode bits 19:16 hold length minus one, so 3..15 give 4..16 bits and 0..2 are treated as 4 bits. Each character makes exactly 2×length `sclk` transitions.
- R4: The half period of `sclk` is H = 2·(PM+1) system cycles, where PM is mode bits 27:24. When mode bit 28 is set, H = 32·(PM+1). `done` is high in the cycle after the (2·length·H)-th rising clock edge that follows the edge accepting `start`.
- R5: `busy` is high from the edge accepting `start` until `done`. `done` lasts exactly one cycle, and `busy` is low in that cycle.
- R6: Mode bit 31 sets the idle level of `sclk`, and `sclk` is back at that level when `done` is high. With mode bit 30 at 0, each bit is sampled on its first clock edge and changed on its second. With mode bit 30 at 1, each bit is changed on the first edge and sampled on the second.
- R7: The chip select is active from the edge accepting `start` through the whole character. Mode bit 20 at 1 makes `csel` low when active; at 0, `csel` is high when active.
- R8: While `hold_sel` is 1 the select stays active between characters, including the `done` cycle. While `hold_sel` is 0 the select is inactive in the `done` cycle, and it is released one edge after `hold_sel` falls while idle.
- R9: A mode load is ignored while `busy` is high and in a cycle in which `start` is high; a load while idle applies to the next character. A `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_word | input | 32 | Mode word to load |
| mode_load | input | 1 | One-cycle strobe that loads `mode_word` when idle |
| start | input | 1 | One-cycle request to send a character |
| hold_sel | input | 1 | Keep the chip select active between characters |
| tx_data | input | 16 | Character to send, right-justified |
| rx_data | output | 16 | Received character, right-justified, valid while `done` is high |
| busy | output | 1 | Character in progress |
| done | output | 1 | One-cycle end-of-character pulse |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csel | output | 1 | Chip select, level set by mode bit 20 |

## Verification
`busy` and the chip select take their new values on the rising edge that accepts `start`. `done` and the received character appear exactly 2·length·H edges later, and a released hold shows one edge after `hold_sel` falls. The bench drives each stimulus at a falling edge and samples 2 ns after each rising edge. It counts rising edges from the accepting edge to the first sample that shows `done`, and compares that count with the value computed from the mode word. A bench-side slave follows `sclk` 1 ns after each transition, using the phase and order it decodes itself. Its captured and returned words are therefore settled before the `done` sample.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  // Character length limits and mode field sizes
  localparam int MAX_BITS = 16;
  localparam int MIN_BITS = 4;
  localparam int PM_FW    = 4;
  localparam int LEN_FW   = 4;
  localparam int NB_W     = $clog2(MAX_BITS + 1);
  localparam int EDGE_W   = $clog2(2 * MAX_BITS);
  localparam int HALF_W   = $clog2(32 * (2 ** PM_FW));

  // Mode word bit positions
  localparam int MW_CPOL  = 31;
  localparam int MW_CPHA  = 30;
  localparam int MW_MSBF  = 29;
  localparam int MW_DIV16 = 28;
  localparam int MW_PM_LO = 24;
  localparam int MW_CSLOW = 20;
  localparam int MW_LEN_LO = 16;

  localparam logic [31:0] MODE_RESET = 32'h0010_0008;

  typedef struct packed {
    logic              cpol;
    logic              cpha;
    logic              msb_first;
    logic              div16;
    logic [PM_FW-1:0]  pm;
    logic              cs_low;
    logic [LEN_FW-1:0] len_m1;
  } mode_t;
endpackage

// File: rtl/spi_eng_clkgen.sv
module spi_eng_clkgen #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          tick
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign tick = run && (cnt_q == limit);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter #(
  parameter int W    = 16,
  parameter int NB_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            msb_first,
  input  logic [NB_W-1:0] nbits,
  input  logic [W-1:0]    tx_word,
  input  logic            advance,
  input  logic            sample,
  input  logic            finish,
  input  logic            miso,
  output logic            mosi,
  output logic [W-1:0]    rx_word
);
  logic [W-1:0]    tx_q, tx_d;
  logic [W-1:0]    rx_q, rx_d, rx_in;
  logic [W-1:0]    out_q, out_d;
  logic [NB_W-1:0] pad;

  assign pad  = NB_W'(W) - nbits;
  assign mosi = msb_first ? tx_q[W-1] : tx_q[0];

  always_comb begin
    tx_d = tx_q;
    if (load)         tx_d = msb_first ? (tx_word << pad) : tx_word;
    else if (advance) tx_d = msb_first ? (tx_q << 1) : (tx_q >> 1);

    rx_in = msb_first ? {rx_q[W-2:0], miso} : {miso, rx_q[W-1:1]};
    if (load)        rx_d = '0;
    else if (sample) rx_d = rx_in;
    else             rx_d = rx_q;

    out_d = msb_first ? rx_d : (rx_d >> pad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      out_q <= '0;
    end else begin
      if (load || advance) tx_q  <= tx_d;
      if (load || sample)  rx_q  <= rx_d;
      if (finish)          out_q <= out_d;
    end
  end

  assign rx_word = out_q;
endmodule

// File: rtl/spi_eng_modereg.sv
module spi_eng_modereg
  import spi_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [31:0]       word_in,
  output logic [31:0]       word_q,
  output logic              cpol,
  output logic              cpha,
  output logic              msb_first,
  output logic              cs_low,
  output logic [NB_W-1:0]   nbits,
  output logic [HALF_W-1:0] half_lim
);
  mode_t             cfg;
  logic [PM_FW:0]    pm_p1;
  logic [HALF_W:0]   half_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= MODE_RESET;
    else if (load_en) word_q <= word_in;
  end

  always_comb begin
    cfg.cpol      = word_q[MW_CPOL];
    cfg.cpha      = word_q[MW_CPHA];
    cfg.msb_first = word_q[MW_MSBF];
    cfg.div16     = word_q[MW_DIV16];
    cfg.pm        = word_q[MW_PM_LO +: PM_FW];
    cfg.cs_low    = word_q[MW_CSLOW];
    cfg.len_m1    = word_q[MW_LEN_LO +: LEN_FW];

    if (cfg.len_m1 < LEN_FW'(MIN_BITS - 1)) nbits = NB_W'(MIN_BITS);
    else                                    nbits = NB_W'(cfg.len_m1) + NB_W'(1);

    pm_p1    = {1'b0, cfg.pm} + (PM_FW + 1)'(1);
    half_cyc = (HALF_W + 1)'(pm_p1) << (cfg.div16 ? 5 : 1);
    half_lim = HALF_W'(half_cyc - (HALF_W + 1)'(1));
  end

  assign cpol      = cfg.cpol;
  assign cpha      = cfg.cpha;
  assign msb_first = cfg.msb_first;
  assign cs_low    = cfg.cs_low;
endmodule

// File: rtl/spi_char_engine.sv
module spi_char_engine
  import spi_eng_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [31:0]         mode_word,
  input  logic                mode_load,
  input  logic                start,
  input  logic                hold_sel,
  input  logic [MAX_BITS-1:0] tx_data,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                busy,
  output logic                done,
  output logic                sclk,
  output logic                mosi,
  input  logic                miso,
  output logic                csel
);
  logic rst_meta, rst_sn;

  logic [31:0]       mode_q;
  logic              cpol, cpha, msb_first, cs_low;
  logic [NB_W-1:0]   nbits;
  logic [HALF_W-1:0] half_lim;

  logic              tick, step, start_ok, load_en, last_edge, smp, adv;
  logic              busy_q, busy_d, done_q, done_d;
  logic              sclk_q, sclk_d, sel_q, sel_d;
  logic [EDGE_W-1:0] edge_q, edge_d, last_idx;

  // Reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sn, rst_meta} <= 2'b00;
    else        {rst_sn, rst_meta} <= {rst_meta, 1'b1};
  end

  assign start_ok = start & ~busy_q;
  assign load_en  = mode_load & ~busy_q & ~start;

  spi_eng_modereg u_mode (
    .clk       (clk),
    .rst_n     (rst_sn),
    .load_en   (load_en),
    .word_in   (mode_word),
    .word_q    (mode_q),
    .cpol      (cpol),
    .cpha      (cpha),
    .msb_first (msb_first),
    .cs_low    (cs_low),
    .nbits     (nbits),
    .half_lim  (half_lim)
  );

  spi_eng_clkgen #(.CW(HALF_W)) u_clk (
    .clk   (clk),
    .rst_n (rst_sn),
    .run   (busy_q),
    .limit (half_lim),
    .tick  (tick)
  );

  // Edge bookkeeping: one step per serial clock transition
  assign step      = busy_q & tick;
  assign last_idx  = EDGE_W'({nbits, 1'b0} - (NB_W + 1)'(1));
  assign last_edge = step & (edge_q == last_idx);
  assign smp       = step & (edge_q[0] == cpha);
  assign adv       = step & (edge_q[0] != cpha) & (edge_q != '0);

  always_comb begin
    busy_d = busy_q;
    if (start_ok)       busy_d = 1'b1;
    else if (last_edge) busy_d = 1'b0;

    edge_d = edge_q;
    if (start_ok)  edge_d = '0;
    else if (step) edge_d = edge_q + EDGE_W'(1);

    if (busy_q) sclk_d = tick ? ~sclk_q : sclk_q;
    else        sclk_d = cpol;

    done_d = last_edge;
    sel_d  = busy_d | hold_sel;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
      sel_q  <= 1'b0;
      edge_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      sclk_q <= sclk_d;
      sel_q  <= sel_d;
      if (start_ok || step) edge_q <= edge_d;
    end
  end

  spi_eng_shifter #(.W(MAX_BITS), .NB_W(NB_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sn),
    .load      (start_ok),
    .msb_first (msb_first),
    .nbits     (nbits),
    .tx_word   (tx_data),
    .advance   (adv),
    .sample    (smp),
    .finish    (last_edge),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_data)
  );

  assign busy = busy_q;
  assign done = done_q;
  assign sclk = sclk_q;
  assign csel = cs_low ? ~sel_q : sel_q;
endmodule

// File: rtl/spi_eng_checks.sv
module spi_eng_checks
  import spi_eng_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            sclk,
  input logic            mosi,
  input logic            csel,
  input logic            cpol,
  input logic            cs_low,
  input logic [NB_W-1:0] nbits,
  input logic [31:0]     mode_q
);
  logic [NB_W:0] toggles;
  logic          sclk_d, busy_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      toggles <= '0;
      sclk_d  <= 1'b0;
      busy_d  <= 1'b0;
    end else begin
      sclk_d <= sclk;
      busy_d <= busy;
      if (start && !busy)                        toggles <= '0;
      else if (busy && busy_d && sclk != sclk_d) toggles <= toggles + (NB_W + 1)'(1);
    end
  end

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r3_toggle_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((toggles + (NB_W + 1)'(sclk != sclk_d)) == {nbits, 1'b0}));

  a_r6_clock_parked: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sclk == cpol));

  a_r7_select_active: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (csel == !cs_low));

  a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(mode_q));

  a_r2_data_moves_with_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busy_d && !$stable(mosi)) |-> !$stable(sclk));
endmodule

bind spi_char_engine spi_eng_checks u_checks (
  .clk    (clk),
  .rst_n  (rst_sn),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .sclk   (sclk),
  .mosi   (mosi),
  .csel   (csel),
  .cpol   (cpol),
  .cs_low (cs_low),
  .nbits  (nbits),
  .mode_q (mode_q)
);

// File: tb/test_spi_char_engine.sv
`timescale 1ns/1ps
module test_spi_char_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mode_word = 32'h0;
  logic        mode_load = 1'b0;
  logic        start = 1'b0;
  logic        hold_sel = 1'b0;
  logic [15:0] tx_data = 16'h0;
  logic [15:0] rx_data;
  logic        busy, done, sclk, mosi, csel;
  logic        miso = 1'b0;

  always #5 clk = ~clk;

  spi_char_engine i_spi_char_engine (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .mode_load(mode_load),
    .start(start), .hold_sel(hold_sel), .tx_data(tx_data), .rx_data(rx_data),
    .busy(busy), .done(done), .sclk(sclk), .mosi(mosi), .miso(miso), .csel(csel)
  );

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  // Bench model of the mode in force
  int m_pol, m_pha, m_msb, m_len, m_half, m_cslow;
  bit lws = 0;
  int last_cyc;
  logic [15:0] last_rx;

  // Bench slave state
  logic [15:0] s_word, s_cap;
  int s_edge, s_si, s_li;
  bit s_armed = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int pol, int pha, int msb, int div, int pm, int cslow, int lenf);
    return (32'(pol) << 31) | (32'(pha) << 30) | (32'(msb) << 29) | (32'(div) << 28) |
           (32'(pm) << 24) | (32'(cslow) << 20) | (32'(lenf) << 16) | 32'h8;
  endfunction

  function automatic int spos(int i);
    return (m_msb != 0) ? (m_len - 1 - i) : i;
  endfunction

  task automatic model(input logic [31:0] w);
    int lf;
    m_pol = int'(w[31]); m_pha = int'(w[30]); m_msb = int'(w[29]);
    lf = int'(w[19:16]);
    m_len = (lf < 3) ? 4 : lf + 1;
    m_half = (w[28] ? 32 : 2) * (int'(w[27:24]) + 1);
    m_cslow = int'(w[20]);
  endtask

  task automatic use_mode(input logic [31:0] w);
    model(w);
    @(negedge clk); mode_word = w; mode_load = 1'b1;
    @(posedge clk); #2; mode_load = 1'b0;
    repeat (2) @(posedge clk);
    #2;
  endtask

  always @(posedge sclk or negedge sclk) begin
    if (s_armed) begin
      #1;
      if ((s_edge % 2) == m_pha) begin
        if (s_si < 16) s_cap[spos(s_si)] = mosi;
        s_si++;
      end else if (s_edge != 0) begin
        s_li++;
        if (s_li < m_len) miso = s_word[spos(s_li)];
      end
      s_edge++;
    end
  end

  task automatic run_char(input logic [15:0] tx, input logic [15:0] sw, input string ctx);
    int cyc, expc, act_lvl;
    logic [15:0] mask;
    expc = 2 * m_len * m_half;
    mask = 16'((32'h1 << m_len) - 1);
    act_lvl = (m_cslow != 0) ? 0 : 1;
    s_word = sw; s_cap = 16'h0; s_edge = 0; s_si = 0; s_li = 0;
    miso = sw[spos(0)];
    s_armed = 1;
    @(negedge clk); tx_data = tx; start = 1'b1; if (lws) mode_load = 1'b1;
    @(posedge clk); #2; start = 1'b0; mode_load = 1'b0;
    chk(csel == act_lvl[0], {"R7 select active after start ", ctx}, int'(csel), act_lvl);
    chk(busy == 1'b1, {"R5 busy after start ", ctx}, int'(busy), 1);
    cyc = 0;
    do begin
      @(posedge clk); #2; cyc++;
    end while (!done && cyc < 5000);
    s_armed = 0;
    last_cyc = cyc; last_rx = rx_data;
    chk(cyc == expc, {"R4 done latency ", ctx}, cyc, expc);
    chk(rx_data == (sw & mask), {"R2 received word ", ctx}, int'(rx_data), int'(sw & mask));
    chk(s_cap == (tx & mask), {"R2 sent word ", ctx}, int'(s_cap), int'(tx & mask));
    chk(s_edge == 2 * m_len, {"R3 clock transitions ", ctx}, s_edge, 2 * m_len);
    chk(sclk == m_pol[0], {"R6 clock idle level at done ", ctx}, int'(sclk), m_pol);
    chk(busy == 1'b0, {"R5 busy low at done ", ctx}, int'(busy), 0);
    chk(csel == (hold_sel ? act_lvl[0] : !act_lvl[0]), {"R8 select at done ", ctx},
        int'(csel), hold_sel ? act_lvl : 1 - act_lvl);
    @(posedge clk); #2;
    chk(done == 1'b0, {"R5 done single cycle ", ctx}, int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int idx;
    int lens[5] = '{4, 5, 8, 11, 16};
    logic [31:0] ma, mb;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk); #2;

    // R1 reset state and default mode
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    chk(sclk == 1'b0, "R1 sclk after reset", int'(sclk), 0);
    chk(csel == 1'b1, "R1 csel after reset", int'(csel), 1);
    model(32'h0010_0008);
    run_char(16'h123A, 16'hFFF5, "R1 default");
    chk(last_cyc == 16, "R1 default timing", last_cyc, 16);
    chk(last_rx == 16'h0005, "R1 default length", int'(last_rx), 5);

    // Sweep of polarity, phase, order, length and prescale
    idx = 0;
    for (int pol = 0; pol < 2; pol++)
      for (int pha = 0; pha < 2; pha++)
        for (int msb = 0; msb < 2; msb++)
          for (int li = 0; li < 5; li++)
            for (int pm = 0; pm < 3; pm++) begin
              use_mode(mk(pol, pha, msb, 0, pm, 1, lens[li] - 1));
              run_char(16'hA5C3 ^ 16'(idx * 16'h1357), 16'h3C96 + 16'(idx * 16'h0F1F), "sweep");
              idx++;
            end

    // Extra divide-by-16
    for (int pm = 0; pm < 2; pm++)
      for (int lf = 3; lf < 5; lf++) begin
        use_mode(mk(pm, 1 - pm, 1, 1, pm, 1, lf));
        run_char(16'h5A69 + 16'(pm), 16'h96A5 - 16'(lf), "R4 div16");
      end

    // R3 short length codes fall back to 4 bits
    for (int lf = 0; lf < 3; lf++) begin
      use_mode(mk(0, 0, 1, 0, 0, 1, lf));
      run_char(16'hBEE7, 16'h0C0D, "R3 clamp");
      chk(last_cyc == 16, "R3 clamp length", last_cyc, 16);
    end

    // R7 active-high select
    use_mode(mk(0, 0, 0, 0, 1, 0, 7));
    chk(csel == 1'b0, "R7 active-high select idle", int'(csel), 0);
    run_char(16'h00C5, 16'h005A, "R7 active-high");

    // R8 select held across characters
    use_mode(mk(1, 1, 1, 0, 0, 1, 9));
    @(negedge clk); hold_sel = 1'b1;
    @(posedge clk); #2;
    chk(csel == 1'b0, "R8 held select while idle", int'(csel), 0);
    run_char(16'h0321, 16'h0123, "R8 first");
    repeat (3) @(posedge clk); #2;
    chk(csel == 1'b0, "R8 select still held", int'(csel), 0);
    run_char(16'h03FE, 16'h0201, "R8 second");
    @(negedge clk); hold_sel = 1'b0;
    @(posedge clk); #2;
    chk(csel == 1'b1, "R8 select released", int'(csel), 1);

    // R9 mode load ignored while busy
    ma = mk(0, 1, 1, 0, 1, 1, 7);
    mb = mk(1, 0, 0, 0, 0, 1, 3);
    use_mode(ma);
    fork
      run_char(16'h00A1, 16'h0037, "R9 load while busy");
      begin
        repeat (6) @(negedge clk);
        mode_word = mb; mode_load = 1'b1;
        @(negedge clk); mode_load = 1'b0;
      end
    join
    run_char(16'h0072, 16'h00E4, "R9 after busy load");
    chk(last_cyc == 64, "R9 mode unchanged after busy load", last_cyc, 64);

    // R9 load together with start
    mode_word = mb; lws = 1;
    run_char(16'h0011, 16'h0088, "R9 load with start");
    lws = 0;
    chk(last_cyc == 64, "R9 load with start ignored for char", last_cyc, 64);
    run_char(16'h0022, 16'h0044, "R9 next after load with start");
    chk(last_cyc == 64, "R9 load with start ignored after", last_cyc, 64);

    // R9 start while busy
    fork
      run_char(16'h0055, 16'h00AA, "R9 start while busy");
      begin
        repeat (10) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
      end
    join
    begin
      int bad = 0;
      for (int i = 0; i < 80; i++) begin
        @(posedge clk); #2;
        if (busy || done) bad++;
      end
      chk(bad == 0, "R9 no extra character", bad, 0);
    end

    // R9 idle load applies
    use_mode(mb);
    run_char(16'h0009, 16'h0006, "R9 idle load");
    chk(last_cyc == 16, "R9 idle load applies", last_cyc, 16);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule